// File: doc/BRIEF.md
# Remote-Transfer Command Controller

The controller sits between a CPU, a local RAM and a link to a remote system. The CPU sends commands on a control input port. The remote side sends messages on an external input port. The block takes one of these cause transactions at a time and decodes it. It then runs the chain of effect transactions that the cause calls for: RAM reads or writes, messages to the remote side on the external output, and responses or notifications to the CPU on the control output. A small register file is held inside and is reachable only through CPU commands.

Every port uses a valid/ready handshake. Each transaction carries a 3-bit opcode, an address and a data word. The RAM port is a request channel. Read data comes back on `ram_rdata_i` in the cycle after a read request is accepted. When both input ports offer a transaction in the same cycle, the external input wins. A dependent step is issued only once the data it needs has returned.

Top module: `xfer_ctrl`

## Requirements
- R1: While rst_ni is low, all three output valids (control out, external out, RAM request) are low. With no input valid, both input readies are high.
- R2: CPU op 0 writes data into the register selected by the low log2(NREGS) address bits and produces no output transaction. CPU op 1 returns control-out op 0 with the same address and that register's value, so address bits above the index are ignored.
- R3: CPU op 2 issues a RAM read at the address, then sends external-out op 0 with the same address and the returned RAM data.
- R4: CPU op 3 sends external-out op 1 with the address and a zero data word, without touching RAM.
- R5: CPU op 4 sends external-out op 3 with the command's address and data.
- R6: External-in op 0 writes its data to RAM at its address and produces nothing on either output port.
- R7: External-in op 1 issues a RAM read at the address, then sends external-out op 2 with that address and the read data.
- R8: External-in op 2 first sends control-out op 1 with its address and data, then writes the same data to RAM at that address.
- R9: External-in op 3 sends control-out op 2 with its address and data.
- R10: When both inputs are valid while the block is idle, the external input is accepted and the control input is held off.
- R11: Only one flow runs at a time. No input is accepted while any output valid is high, and at most one of the three output valids is high in any cycle.
- R12: An output held valid without ready stays valid with opcode, address and data unchanged until accepted.
- R13: Unassigned opcodes (CPU 5 to 7, external 4 to 7) are accepted and dropped. They change no register and no RAM word and produce no output.
- R14: RAM read data is taken in the cycle after the read handshake. The dependent output is not raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_in_valid_i | input | 1 | CPU command valid |
| ctl_in_ready_o | output | 1 | CPU command accepted |
| ctl_in_op_i | input | 3 | CPU command opcode |
| ctl_in_addr_i | input | ADDR_W | CPU command address |
| ctl_in_data_i | input | DATA_W | CPU command data |
| ctl_out_valid_o | output | 1 | Response/notification valid |
| ctl_out_ready_i | input | 1 | CPU takes response |
| ctl_out_op_o | output | 3 | Response opcode |
| ctl_out_addr_o | output | ADDR_W | Response address |
| ctl_out_data_o | output | DATA_W | Response data |
| ext_in_valid_i | input | 1 | Remote message valid |
| ext_in_ready_o | output | 1 | Remote message accepted |
| ext_in_op_i | input | 3 | Remote message opcode |
| ext_in_addr_i | input | ADDR_W | Remote message address |
| ext_in_data_i | input | DATA_W | Remote message data |
| ext_out_valid_o | output | 1 | Outgoing remote message valid |
| ext_out_ready_i | input | 1 | Link takes message |
| ext_out_op_o | output | 3 | Outgoing opcode |
| ext_out_addr_o | output | ADDR_W | Outgoing address |
| ext_out_data_o | output | DATA_W | Outgoing data |
| ram_req_valid_o | output | 1 | RAM request valid |
| ram_req_ready_i | input | 1 | RAM accepts request |
| ram_we_o | output | 1 | 1 = write, 0 = read |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_wdata_o | output | DATA_W | RAM write data |
| ram_rdata_i | input | DATA_W | RAM read data, one cycle after read handshake |

## Verification
The bench uses the defaults: 16-bit address, 32-bit data and eight registers. With these values every register can be written and read back. Addresses 0 to 15 are swept for every flow, and the second half of that range aliases the register index, so the ignored upper address bits are exercised. The small opcode space allows every assigned and unassigned opcode on both inputs to be tried. A cyclic ready pattern on RAM and both outputs brings backpressure and the one-cycle read latency into every chained flow.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int OP_W = 3;
  typedef logic [OP_W-1:0] op_t;

  // CPU commands
  localparam op_t C_REG_WR = 3'd0;
  localparam op_t C_REG_RD = 3'd1;
  localparam op_t C_WRITE  = 3'd2;
  localparam op_t C_READ   = 3'd3;
  localparam op_t C_IRQ    = 3'd4;

  // remote messages, both directions
  localparam op_t X_WR      = 3'd0;
  localparam op_t X_RD      = 3'd1;
  localparam op_t X_RD_RESP = 3'd2;
  localparam op_t X_IRQ     = 3'd3;

  // CPU-bound responses
  localparam op_t N_REG_RESP = 3'd0;
  localparam op_t N_RD_RESP  = 3'd1;
  localparam op_t N_IRQ      = 3'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_RAM_RD, S_RAM_WAIT, S_EXT, S_CTL, S_RAM_WR
  } state_e;
endpackage

// File: rtl/xfer_arb.sv
module xfer_arb
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              ctl_valid_i,
  input  op_t               ctl_op_i,
  input  logic [ADDR_W-1:0] ctl_addr_i,
  input  logic [DATA_W-1:0] ctl_data_i,
  output logic              ctl_ready_o,
  input  logic              ext_valid_i,
  input  op_t               ext_op_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic              ext_ready_o,
  output logic              take_o,
  output logic              src_ext_o,
  output op_t               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  // fixed priority: remote side first
  assign ext_ready_o = idle_i;
  assign ctl_ready_o = idle_i && !ext_valid_i;
  assign src_ext_o   = ext_valid_i;
  assign take_o      = idle_i && (ext_valid_i || ctl_valid_i);
  assign op_o        = ext_valid_i ? ext_op_i   : ctl_op_i;
  assign addr_o      = ext_valid_i ? ext_addr_i : ctl_addr_i;
  assign data_o      = ext_valid_i ? ext_data_i : ctl_data_i;

  // R10
  ext_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_valid_i && ctl_valid_i && idle_i) |-> (!ctl_ready_o && ext_ready_o && src_ext_o));
endmodule

// File: rtl/xfer_regs.sv
module xfer_regs #(
  parameter int NREGS  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))  regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[idx_i];
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              src_ext_i,
  input  op_t               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              reg_we_o,
  output logic              idle_o,
  output logic              ctl_out_valid_o,
  input  logic              ctl_out_ready_i,
  output op_t               ctl_out_op_o,
  output logic [ADDR_W-1:0] ctl_out_addr_o,
  output logic [DATA_W-1:0] ctl_out_data_o,
  output logic              ext_out_valid_o,
  input  logic              ext_out_ready_i,
  output op_t               ext_out_op_o,
  output logic [ADDR_W-1:0] ext_out_addr_o,
  output logic [DATA_W-1:0] ext_out_data_o,
  output logic              ram_req_valid_o,
  input  logic              ram_req_ready_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  state_e            st_q;
  op_t               out_op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              then_wr_q;

  assign idle_o   = (st_q == S_IDLE);
  assign reg_we_o = take_i && !src_ext_i && (op_i == C_REG_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      out_op_q  <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      then_wr_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (take_i) begin
          addr_q    <= addr_i;
          data_q    <= data_i;
          then_wr_q <= 1'b0;
          if (!src_ext_i) begin
            unique case (op_i)
              C_REG_RD: begin st_q <= S_CTL;    out_op_q <= N_REG_RESP; data_q <= reg_rdata_i; end
              C_WRITE:  begin st_q <= S_RAM_RD; out_op_q <= X_WR; end
              C_READ:   begin st_q <= S_EXT;    out_op_q <= X_RD; data_q <= '0; end
              C_IRQ:    begin st_q <= S_EXT;    out_op_q <= X_IRQ; end
              default:  st_q <= S_IDLE;  // register write or unassigned
            endcase
          end else begin
            unique case (op_i)
              X_WR:      st_q <= S_RAM_WR;
              X_RD:      begin st_q <= S_RAM_RD; out_op_q <= X_RD_RESP; end
              X_RD_RESP: begin st_q <= S_CTL;    out_op_q <= N_RD_RESP; then_wr_q <= 1'b1; end
              X_IRQ:     begin st_q <= S_CTL;    out_op_q <= N_IRQ; end
              default:   st_q <= S_IDLE;
            endcase
          end
        end
        S_RAM_RD:   if (ram_req_ready_i) st_q <= S_RAM_WAIT;
        S_RAM_WAIT: begin data_q <= ram_rdata_i; st_q <= S_EXT; end
        S_EXT:      if (ext_out_ready_i) st_q <= S_IDLE;
        S_CTL:      if (ctl_out_ready_i) st_q <= then_wr_q ? S_RAM_WR : S_IDLE;
        S_RAM_WR:   if (ram_req_ready_i) st_q <= S_IDLE;
        default:    st_q <= S_IDLE;
      endcase
    end
  end

  assign ram_req_valid_o = (st_q == S_RAM_RD) || (st_q == S_RAM_WR);
  assign ram_we_o        = (st_q == S_RAM_WR);
  assign ram_addr_o      = addr_q;
  assign ram_wdata_o     = data_q;

  assign ext_out_valid_o = (st_q == S_EXT);
  assign ext_out_op_o    = out_op_q;
  assign ext_out_addr_o  = addr_q;
  assign ext_out_data_o  = data_q;

  assign ctl_out_valid_o = (st_q == S_CTL);
  assign ctl_out_op_o    = out_op_q;
  assign ctl_out_addr_o  = addr_q;
  assign ctl_out_data_o  = data_q;

  // R11
  single_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctl_out_valid_o, ext_out_valid_o, ram_req_valid_o}));
  // R11
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_out_valid_o || ext_out_valid_o || ram_req_valid_o) |-> !take_i);
  // R12
  ext_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_out_valid_o && !ext_out_ready_i) |=>
      (ext_out_valid_o && $stable(ext_out_op_o) && $stable(ext_out_addr_o) && $stable(ext_out_data_o)));
  // R12
  ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_out_valid_o && !ctl_out_ready_i) |=>
      (ctl_out_valid_o && $stable(ctl_out_op_o) && $stable(ctl_out_addr_o) && $stable(ctl_out_data_o)));
  // R14
  rd_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_req_valid_o && !ram_we_o && ram_req_ready_i) |=> (!ram_req_valid_o && !ext_out_valid_o));
  // R8
  resp_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_out_valid_o && ctl_out_ready_i && ctl_out_op_o == N_RD_RESP) |=>
      (ram_req_valid_o && ram_we_o && $stable(ram_addr_o)));
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NREGS  = 8,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_in_valid_i,
  output logic              ctl_in_ready_o,
  input  logic [2:0]        ctl_in_op_i,
  input  logic [ADDR_W-1:0] ctl_in_addr_i,
  input  logic [DATA_W-1:0] ctl_in_data_i,
  output logic              ctl_out_valid_o,
  input  logic              ctl_out_ready_i,
  output logic [2:0]        ctl_out_op_o,
  output logic [ADDR_W-1:0] ctl_out_addr_o,
  output logic [DATA_W-1:0] ctl_out_data_o,
  input  logic              ext_in_valid_i,
  output logic              ext_in_ready_o,
  input  logic [2:0]        ext_in_op_i,
  input  logic [ADDR_W-1:0] ext_in_addr_i,
  input  logic [DATA_W-1:0] ext_in_data_i,
  output logic              ext_out_valid_o,
  input  logic              ext_out_ready_i,
  output logic [2:0]        ext_out_op_o,
  output logic [ADDR_W-1:0] ext_out_addr_o,
  output logic [DATA_W-1:0] ext_out_data_o,
  output logic              ram_req_valid_o,
  input  logic              ram_req_ready_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  logic              idle, take, src_ext, reg_we;
  op_t               sel_op;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_data, reg_rdata;

  xfer_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arb_i (
    .clk_i, .rst_ni, .idle_i(idle),
    .ctl_valid_i(ctl_in_valid_i), .ctl_op_i(ctl_in_op_i), .ctl_addr_i(ctl_in_addr_i),
    .ctl_data_i(ctl_in_data_i), .ctl_ready_o(ctl_in_ready_o),
    .ext_valid_i(ext_in_valid_i), .ext_op_i(ext_in_op_i), .ext_addr_i(ext_in_addr_i),
    .ext_data_i(ext_in_data_i), .ext_ready_o(ext_in_ready_o),
    .take_o(take), .src_ext_o(src_ext), .op_o(sel_op), .addr_o(sel_addr), .data_o(sel_data)
  );

  xfer_regs #(.NREGS(NREGS), .DATA_W(DATA_W)) regs_i (
    .clk_i, .rst_ni, .we_i(reg_we), .idx_i(sel_addr[IDX_W-1:0]),
    .wdata_i(sel_data), .rdata_o(reg_rdata)
  );

  xfer_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk_i, .rst_ni, .take_i(take), .src_ext_i(src_ext), .op_i(sel_op),
    .addr_i(sel_addr), .data_i(sel_data), .reg_rdata_i(reg_rdata),
    .reg_we_o(reg_we), .idle_o(idle),
    .ctl_out_valid_o, .ctl_out_ready_i, .ctl_out_op_o, .ctl_out_addr_o, .ctl_out_data_o,
    .ext_out_valid_o, .ext_out_ready_i, .ext_out_op_o, .ext_out_addr_o, .ext_out_data_o,
    .ram_req_valid_o, .ram_req_ready_i, .ram_we_o, .ram_addr_o, .ram_wdata_o, .ram_rdata_i
  );
endmodule

// File: tb/xfer_ctrl_tb_top.sv
module xfer_ctrl_tb_top;
  localparam int AW = 16, DW = 32, NR = 8;
  localparam logic [1:0] P_CTL = 2'd1, P_EXT = 2'd2, P_RAM = 2'd3;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic ctl_v = 0, ext_v = 0;
  logic [2:0] ctl_op = 0, ext_op = 0;
  logic [AW-1:0] ctl_a = 0, ext_a = 0;
  logic [DW-1:0] ctl_d = 0, ext_d = 0;
  logic ctl_in_ready_o, ext_in_ready_o;
  logic ctl_out_valid_o, ext_out_valid_o, ram_req_valid_o, ram_we_o;
  logic ctl_out_rdy = 1, ext_out_rdy = 1, ram_rdy = 1;
  logic [2:0] ctl_out_op_o, ext_out_op_o;
  logic [AW-1:0] ctl_out_addr_o, ext_out_addr_o, ram_addr_o;
  logic [DW-1:0] ctl_out_data_o, ext_out_data_o, ram_wdata_o;
  logic [DW-1:0] ram_rdata = '0;

  xfer_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NREGS(NR)) dut_i (
    .clk_i(clk), .rst_ni,
    .ctl_in_valid_i(ctl_v), .ctl_in_ready_o, .ctl_in_op_i(ctl_op), .ctl_in_addr_i(ctl_a), .ctl_in_data_i(ctl_d),
    .ctl_out_valid_o, .ctl_out_ready_i(ctl_out_rdy), .ctl_out_op_o, .ctl_out_addr_o, .ctl_out_data_o,
    .ext_in_valid_i(ext_v), .ext_in_ready_o, .ext_in_op_i(ext_op), .ext_in_addr_i(ext_a), .ext_in_data_i(ext_d),
    .ext_out_valid_o, .ext_out_ready_i(ext_out_rdy), .ext_out_op_o, .ext_out_addr_o, .ext_out_data_o,
    .ram_req_valid_o, .ram_req_ready_i(ram_rdy), .ram_we_o, .ram_addr_o, .ram_wdata_o, .ram_rdata_i(ram_rdata)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit stall_en = 0, done = 0;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] exp_mem [16];
  logic [DW-1:0] exp_reg [NR];
  logic [52:0] ev_q[$];
  logic rd_pend = 0;
  logic [3:0] rd_addr = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [52:0] ev(input logic [1:0] p, input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    return {p, op, a, d};
  endfunction

  task automatic expect_ev(input logic [52:0] e, input string tag);
    logic [52:0] a = '0;
    if (ev_q.size() != 0) a = ev_q.pop_front();
    chk(a == e, tag, 64'(a), 64'(e));
  endtask

  task automatic expect_none(input string tag);
    chk(ev_q.size() == 0, tag, 64'(ev_q.size()), 64'd0);
    ev_q.delete();
  endtask

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  task automatic send_ctl(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ctl_v = 1; ctl_op = op; ctl_a = a; ctl_d = d;
    #1;
    while (!ctl_in_ready_o) begin @(negedge clk); #1; end
    @(negedge clk);
    ctl_v = 0;
  endtask

  task automatic send_ext(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ext_v = 1; ext_op = op; ext_a = a; ext_d = d;
    #1;
    while (!ext_in_ready_o) begin @(negedge clk); #1; end
    @(negedge clk);
    ext_v = 0;
  endtask

  // ready patterns and RAM model; handshakes recorded away from the edge
  always @(negedge clk) begin
    cyc++;
    ram_rdy     = !stall_en || (cyc % 3 == 0);
    ext_out_rdy = !stall_en || (cyc % 3 == 1);
    ctl_out_rdy = !stall_en || (cyc % 3 == 2);
    #2;
    if (rd_pend) begin ram_rdata = mem[rd_addr]; rd_pend = 0; end
    if (rst_ni) begin
      if (ram_req_valid_o && ram_rdy) begin
        if (ram_we_o) begin
          mem[ram_addr_o[3:0]] = ram_wdata_o;
          ev_q.push_back(ev(P_RAM, 3'd0, ram_addr_o, ram_wdata_o));
        end else begin
          rd_pend = 1; rd_addr = ram_addr_o[3:0];
        end
      end
      if (ctl_out_valid_o && ctl_out_rdy) ev_q.push_back(ev(P_CTL, ctl_out_op_o, ctl_out_addr_o, ctl_out_data_o));
      if (ext_out_valid_o && ext_out_rdy) ev_q.push_back(ev(P_EXT, ext_out_op_o, ext_out_addr_o, ext_out_data_o));
    end
  end

  // R12: backpressure hold observed at the ports
  logic pv_e = 0, pr_e = 0;
  logic [50:0] pp_e = '0;
  always @(negedge clk) begin
    #3;
    if (rst_ni && pv_e && !pr_e)
      chk(ext_out_valid_o && {ext_out_op_o, ext_out_addr_o, ext_out_data_o} == pp_e, "R12 ext hold",
          64'({ext_out_valid_o, ext_out_op_o, ext_out_addr_o, ext_out_data_o}), 64'({1'b1, pp_e}));
    pv_e = ext_out_valid_o; pr_e = ext_out_rdy;
    pp_e = {ext_out_op_o, ext_out_addr_o, ext_out_data_o};
  end

  task automatic finish_sim();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog act=running exp=done");
      finish_sim();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h3C00_0000 + 32'(i) * 32'd7;
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk(!ctl_out_valid_o && !ext_out_valid_o && !ram_req_valid_o, "R1 valids in reset",
        64'({ctl_out_valid_o, ext_out_valid_o, ram_req_valid_o}), 64'd0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk); #1;
    chk(ctl_in_ready_o && ext_in_ready_o, "R1 readies idle", 64'({ctl_in_ready_o, ext_in_ready_o}), 64'd3);

    // R2 registers, reads swept over 16 addresses to cover index aliasing
    for (int i = 0; i < NR; i++) begin
      exp_reg[i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
      send_ctl(3'd0, AW'(i), exp_reg[i]);
    end
    settle(); expect_none("R2 write silent");
    for (int i = 0; i < 16; i++) begin
      send_ctl(3'd1, AW'(i), 32'hFFFF_FFFF); settle();
      expect_ev(ev(P_CTL, 3'd0, AW'(i), exp_reg[i % NR]), "R2 read");
    end

    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      for (int a = 0; a < 16; a++) begin
        // R3 and R14: data returned one cycle after the read handshake
        send_ctl(3'd2, AW'(a), 32'h0); settle();
        expect_ev(ev(P_EXT, 3'd0, AW'(a), exp_mem[a]), "R3 write flow");
        expect_none("R3 nothing else");
        // R4
        send_ctl(3'd3, AW'(a), 32'h1234_5678); settle();
        expect_ev(ev(P_EXT, 3'd1, AW'(a), 32'h0), "R4 read request");
        // R5
        send_ctl(3'd4, AW'(a), 32'hC0DE_0000 | 32'(a)); settle();
        expect_ev(ev(P_EXT, 3'd3, AW'(a), 32'hC0DE_0000 | 32'(a)), "R5 irq out");
        // R6
        exp_mem[a] = 32'h7000_0000 | (32'(pass) << 8) | 32'(a);
        send_ext(3'd0, AW'(a), exp_mem[a]); settle();
        expect_ev(ev(P_RAM, 3'd0, AW'(a), exp_mem[a]), "R6 ram write");
        expect_none("R6 no output");
        // R7
        send_ext(3'd1, AW'(a), 32'h0); settle();
        expect_ev(ev(P_EXT, 3'd2, AW'(a), exp_mem[a]), "R7 read response");
        // R8: notify then store
        exp_mem[a] = 32'h9900_0000 | (32'(pass) << 8) | 32'(a);
        send_ext(3'd2, AW'(a), exp_mem[a]); settle();
        expect_ev(ev(P_CTL, 3'd1, AW'(a), exp_mem[a]), "R8 notify first");
        expect_ev(ev(P_RAM, 3'd0, AW'(a), exp_mem[a]), "R8 then ram write");
        // R9
        send_ext(3'd3, AW'(a), 32'h5500_0000 | 32'(a)); settle();
        expect_ev(ev(P_CTL, 3'd2, AW'(a), 32'h5500_0000 | 32'(a)), "R9 irq in");
      end
    end
    stall_en = 0;
    settle(); ev_q.delete();

    // R10 / R11
    @(negedge clk);
    ctl_v = 1; ctl_op = 3'd4; ctl_a = 16'd5; ctl_d = 32'hAAAA_0005;
    ext_v = 1; ext_op = 3'd3; ext_a = 16'd9; ext_d = 32'hBBBB_0009;
    #1;
    chk(ext_in_ready_o && !ctl_in_ready_o, "R10 ext wins", 64'({ext_in_ready_o, ctl_in_ready_o}), 64'd2);
    @(negedge clk); ext_v = 0; #1;
    chk(!ctl_in_ready_o && !ext_in_ready_o, "R11 busy blocks", 64'({ctl_in_ready_o, ext_in_ready_o}), 64'd0);
    while (!ctl_in_ready_o) begin @(negedge clk); #1; end
    @(negedge clk); ctl_v = 0;
    settle();
    expect_ev(ev(P_CTL, 3'd2, 16'd9, 32'hBBBB_0009), "R10 ext flow first");
    expect_ev(ev(P_EXT, 3'd3, 16'd5, 32'hAAAA_0005), "R10 ctl flow second");

    // R13
    for (int op = 5; op < 8; op++) send_ctl(3'(op), 16'd3, 32'hFFFF_FFFF);
    for (int op = 4; op < 8; op++) send_ext(3'(op), 16'd3, 32'hFFFF_FFFF);
    settle(); expect_none("R13 no output");
    send_ctl(3'd1, 16'd3, 32'h0); settle();
    expect_ev(ev(P_CTL, 3'd0, 16'd3, exp_reg[3]), "R13 register intact");
    send_ext(3'd1, 16'd3, 32'h0); settle();
    expect_ev(ev(P_EXT, 3'd2, 16'd3, exp_mem[3]), "R13 ram intact");

    done = 1;
    finish_sim();
  end
endmodule